// File: doc/BRIEF.md
# Power-Controller System Watchdog

This block is the system watchdog of a power-management controller. Software reaches it through a small parallel register port. It switches the watchdog on and off, chooses one of four timeout periods, and sends a keepalive by writing a clear bit. The watchdog counts down on a slow single-cycle tick. When the count runs out, it raises a one-cycle expiry pulse together with either a restart request or a shutdown request.

Two auto-clear enables keep the count at its reload value while the system reports sleep mode or off mode. A build parameter selects a variant that has only the sleep auto-clear. A new timeout select takes effect only once the count has been cleared. The clear must come first, either in the cycle just before the timeout write or later. Software can read back a status register to find a watchdog that is already running and the period it is actually using. A combinational helper rounds a requested number of seconds up to the nearest supported timeout code.

Top module: `pmic_wdog`

## Requirements
- R1: After reset, every register reads 0. This means enabled=0, timeout code 0, auto-clears off, restart-enable off and active code 0. The outputs expire, restart_req and shutdown_req are 0.
- R2: Register 0 (addr 0) bit 0 is the enable. Bits 2:1 are the timeout code: 0 = 2 s, 1 = 16 s, 2 = 64 s, 3 = 128 s. One second is TICKS_PER_SEC ticks. While the watchdog is enabled, the tick that ends a full period after the last load gives expiry. The tick before it does not.
- R3: Writing 1 to bit 0 of register 1 (addr 1) clears the watchdog. The full period of the active code is reloaded, so the period counts again from the clear.
- R4: A timeout code written in the cycle right after a clear becomes active at once and is loaded. A code written at any other time is stored in register 0 but becomes active only at the next clear. Register 3 (addr 3) bits 2:1 show the active code and bit 0 shows the enable.
- R5: On expiry, expire is high for exactly one cycle. It rises in the cycle after the tick that ended the period. The count reloads, and the next expiry comes one full period later.
- R6: Register 2 (addr 2) bit 0 is restart-enable. On expiry, restart_req pulses with expire if this bit is 1. If the bit is 0, shutdown_req pulses instead. The two never pulse together.
- R7: The clear bit is self-clearing. Bit 0 of register 1 reads 1 in the cycle after a clear write and 0 after that.
- R8: Register 0 bit 3 enables sleep auto-clear and bit 4 enables off auto-clear. Bit 4 exists only when HAS_OFF_AC=1. While the enabled mode input is high, the count is held at its reload value and no expiry occurs. A mode input whose enable bit is 0 has no effect.
- R9: While the enable bit is 0, ticks cause no expiry.
- R10: req_code is the rounded timeout code for req_secs. Values 0..2 give 0, 3..16 give 1, 17..64 give 2 and 65..255 give 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle time-base tick |
| sleep_mode | input | 1 | System is in sleep mode |
| off_mode | input | 1 | System is in off mode |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| req_secs | input | 8 | Requested timeout in seconds |
| req_code | output | 2 | Rounded timeout code for req_secs |
| expire | output | 1 | One-cycle expiry pulse |
| restart_req | output | 1 | Expiry requests a restart |
| shutdown_req | output | 1 | Expiry requests a shutdown |

## Verification
The countdown is driven by tick trains one tick short of a period and exactly a full period. This runs across the 2 s, 16 s and 64 s codes, which separates off-by-one reload errors from period decode errors. A clear partway through a period, an idle cycle before the timeout write versus a write right after the clear, and a disabled run tell apart a clear that reloads, a code that is latched too early or too late, and a stopped counter. The auto-clear cases hold each mode input high with its enable set and with it cleared, to show that only an enabled mode holds the count. The rounding helper is tested at both edges of each band.

// File: rtl/pmic_wdog.sv
module pmic_wdog #(
  parameter int TICKS_PER_SEC = 2,
  parameter bit HAS_OFF_AC    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sleep_mode,
  input  logic       off_mode,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] req_secs,
  output logic [1:0] req_code,
  output logic       expire,
  output logic       restart_req,
  output logic       shutdown_req
);
  localparam int W = $clog2(128 * TICKS_PER_SEC + 1);

  function automatic logic [W-1:0] period(input logic [1:0] code);
    int secs;
    case (code)
      2'd0:    secs = 2;
      2'd1:    secs = 16;
      2'd2:    secs = 64;
      default: secs = 128;
    endcase
    return W'(secs * TICKS_PER_SEC);
  endfunction

  logic         en_q, sleep_ac_q, off_ac_q, restart_en_q, clr_d;
  logic [1:0]   tsel_q, act_q;
  logic [W-1:0] cnt;

  wire cfg_wr = wr_en && addr == 2'd0;
  wire sw_clr = wr_en && addr == 2'd1 && wdata[0];
  wire hold   = (sleep_mode && sleep_ac_q) || (off_mode && off_ac_q);
  wire hit    = en_q && !sw_clr && !hold && !(cfg_wr && clr_d) && tick && cnt == W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; tsel_q <= 2'd0; sleep_ac_q <= 1'b0; off_ac_q <= 1'b0;
      restart_en_q <= 1'b0; clr_d <= 1'b0;
    end else begin
      clr_d <= sw_clr;
      if (cfg_wr) begin
        en_q       <= wdata[0];
        tsel_q     <= wdata[2:1];
        sleep_ac_q <= wdata[3];
        off_ac_q   <= HAS_OFF_AC & wdata[4];
      end
      if (wr_en && addr == 2'd2) restart_en_q <= wdata[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q <= 2'd0;
      cnt   <= period(2'd0);
    end else if (!en_q) begin
      act_q <= tsel_q;
      cnt   <= period(tsel_q);
    end else if (sw_clr || hold) begin
      act_q <= tsel_q;
      cnt   <= period(tsel_q);
    end else if (cfg_wr && clr_d) begin
      act_q <= wdata[2:1];
      cnt   <= period(wdata[2:1]);
    end else if (tick) begin
      cnt <= (cnt == W'(1)) ? period(act_q) : cnt - W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      expire <= 1'b0; restart_req <= 1'b0; shutdown_req <= 1'b0;
    end else begin
      expire       <= hit;
      restart_req  <= hit && restart_en_q;
      shutdown_req <= hit && !restart_en_q;
    end

  always_comb
    case (addr)
      2'd0:    rdata = {3'b0, off_ac_q, sleep_ac_q, tsel_q, en_q};
      2'd1:    rdata = {7'b0, clr_d};
      2'd2:    rdata = {7'b0, restart_en_q};
      default: rdata = {5'b0, act_q, en_q};
    endcase

  assign req_code = (req_secs <= 8'd2)  ? 2'd0 :
                    (req_secs <= 8'd16) ? 2'd1 :
                    (req_secs <= 8'd64) ? 2'd2 : 2'd3;

  p_cnt_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0 && cnt <= period(act_q));
  p_clr_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> cnt == period(act_q) && act_q == $past(tsel_q));
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
  p_one_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (restart_req ^ shutdown_req));
  p_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !expire |-> !restart_req && !shutdown_req);
  p_selfclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_clr |=> rdata[0] == 1'b0 || addr != 2'd1);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !expire);
  p_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !expire);
endmodule

// File: tb/test_pmic_wdog.sv
module test_pmic_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 2;

  logic clk = 0, rst_n = 0, tick = 0, sleep_mode = 0, off_mode = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, req_secs = 0;
  logic [1:0] req_code;
  logic expire, restart_req, shutdown_req;
  int checks = 0, errors = 0;
  int nexp, last, nrst, nsd;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmic_wdog #(.TICKS_PER_SEC(TPS), .HAS_OFF_AC(1'b1)) i_pmic_wdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep_mode(sleep_mode), .off_mode(off_mode),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .req_secs(req_secs),
    .req_code(req_code), .expire(expire), .restart_req(restart_req), .shutdown_req(shutdown_req));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic run_ticks(input int n);
    nexp = 0; last = 0; nrst = 0; nsd = 0;
    for (int i = 1; i <= n; i++) begin
      tick = 1;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        tick = 0;
        if (expire) begin nexp++; last = i; end
        if (restart_req) nrst++;
        if (shutdown_req) nsd++;
      end
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 register after reset", d, 0);
    end
    chk("R1 outputs after reset", {expire, restart_req, shutdown_req}, 0);
  endtask

  task automatic t_basic;
    wr(0, 8'h01); wr(1, 8'h01);
    run_ticks(2*TPS - 1);
    chk("R2 no expiry one tick short of 2s", nexp, 0);
    run_ticks(1);
    chk("R2 expiry on last tick of 2s", nexp, 1);
    chk("R6 shutdown when restart-enable 0", nsd, 1);
    chk("R6 no restart when restart-enable 0", nrst, 0);
    run_ticks(2*TPS);
    chk("R5 next expiry one period later", last, 2*TPS);
    chk("R5 single pulse per expiry", nexp, 1);
  endtask

  task automatic t_restart;
    wr(2, 8'h01); wr(0, 8'h03); wr(1, 8'h01);
    run_ticks(16*TPS - 1);
    chk("R2 no expiry one tick short of 16s", nexp, 0);
    run_ticks(1);
    chk("R2 expiry at 16s", nexp, 1);
    chk("R6 restart when restart-enable 1", nrst, 1);
    chk("R6 no shutdown when restart-enable 1", nsd, 0);
    wr(2, 8'h00);
  endtask

  task automatic t_ping;
    wr(0, 8'h01); wr(1, 8'h01);
    run_ticks(2*TPS - 1);
    wr(1, 8'h01);
    run_ticks(2*TPS - 1);
    chk("R3 clear restarts countdown", nexp, 0);
    run_ticks(1);
    chk("R3 expiry full period after clear", nexp, 1);
  endtask

  task automatic t_latch;
    logic [7:0] d;
    wr(0, 8'h01); wr(1, 8'h01);
    @(negedge clk);
    wr(0, 8'h07);
    rd(3, d);
    chk("R4 active code unchanged without clear", d[2:1], 0);
    run_ticks(2*TPS);
    chk("R4 old period still used", last, 2*TPS);
    wr(1, 8'h01);
    rd(3, d);
    chk("R4 code active after clear", d[2:1], 3);
    wr(0, 8'h01); wr(1, 8'h01);
    wr(0, 8'h05);
    rd(3, d);
    chk("R4 code active right after clear", d[2:1], 2);
    run_ticks(64*TPS - 1);
    chk("R4 no expiry one short of 64s", nexp, 0);
    run_ticks(1);
    chk("R4 expiry at 64s", nexp, 1);
  endtask

  task automatic t_selfclr;
    logic [7:0] d;
    wr(1, 8'h01);
    rd(1, d);
    chk("R7 clear reads 1 next cycle", d[0], 1);
    @(negedge clk);
    rd(1, d);
    chk("R7 clear reads 0 afterwards", d[0], 0);
  endtask

  task automatic t_auto;
    logic [7:0] d;
    wr(0, 8'h09); wr(1, 8'h01);
    sleep_mode = 1;
    run_ticks(5*TPS);
    chk("R8 sleep auto-clear holds", nexp, 0);
    sleep_mode = 0;
    run_ticks(2*TPS);
    chk("R8 counts after sleep ends", last, 2*TPS);
    wr(0, 8'h01); wr(1, 8'h01);
    sleep_mode = 1;
    run_ticks(2*TPS);
    chk("R8 sleep ignored without enable", last, 2*TPS);
    sleep_mode = 0;
    wr(0, 8'h11); wr(1, 8'h01);
    rd(0, d);
    chk("R8 off auto-clear bit readback", d[4], 1);
    off_mode = 1;
    run_ticks(5*TPS);
    chk("R8 off auto-clear holds", nexp, 0);
    wr(0, 8'h01); wr(1, 8'h01);
    run_ticks(2*TPS);
    chk("R8 off ignored without enable", last, 2*TPS);
    off_mode = 0;
  endtask

  task automatic t_disable;
    logic [7:0] d;
    wr(0, 8'h00);
    run_ticks(3*TPS);
    chk("R9 no expiry while disabled", nexp, 0);
    rd(3, d);
    chk("R9 status shows stopped", d[0], 0);
  endtask

  task automatic t_round;
    int ins[8] = '{0, 2, 3, 16, 17, 64, 65, 255};
    int exps[8] = '{0, 0, 1, 1, 2, 2, 3, 3};
    for (int i = 0; i < 8; i++) begin
      req_secs = ins[i][7:0]; #1;
      chk($sformatf("R10 rounding of %0d", ins[i]), req_code, exps[i]);
    end
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_basic;
    t_restart;
    t_ping;
    t_latch;
    t_selfclr;
    t_auto;
    t_disable;
    t_round;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule